// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block lets a host reach PCI configuration space through two registers. An 8-byte address register names a target: a bus number, a device/function number and a dword register offset. A 4-byte data window then carries configuration reads and writes of 1, 2 or 4 bytes. Each window access becomes one request on a downstream request/response port. The request carries the bus, devfn, dword offset, size, byte enables and data.

The host side is big-endian and the configuration side is little-endian. The bridge reverses the bytes of each transfer according to its size and steers them onto the byte lane picked by the low two bits of the window offset. An external lookup watches the selected bus/devfn and reports two things: whether a device answers there, and whether the device has the 4 KB extended space or only the 256-byte conventional space. An access to a missing device, or to an offset past the end of the device's space, never reaches the downstream port.

Only one configuration request is in flight at a time. Every host access finishes with a one-cycle `host_ready` pulse. For a window access that goes downstream, this pulse comes only after the downstream response.

Top module: `cfg_bridge`

## Requirements
- R1: After reset, `host_ready` and `cfg_req_valid` are low, and the address register reads back as zero.
- R2: An 8-byte write at host offset 0x000 stores all 64 bits into the address register, and an 8-byte read returns them. `sel_bus` shows bits 59:52 of the register and `sel_devfn` shows bits 51:44.
- R3: A forwarded request carries `sel_bus` and `sel_devfn`, and its offset is register bits 43:32 with bits 1:0 forced to zero.
- R4: A host access hits the data window when its offset with bits 1:0 cleared equals 0x008. Bits 1:0 then select the starting byte lane, and `cfg_req_be` has one bit set for each byte of the access from that lane upward. Legal window accesses are 1 byte at any lane, 2 bytes at lane 0 or 2, and 4 bytes at lane 0. `host_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes, and code 3 means 8 bytes.
- R5: Write data is the right-justified host value in big-endian byte order. It is byte-reversed within the access width and shifted up to the selected lane on `cfg_req_wdata`.
- R6: Read data is the response dword shifted down from the selected lane, cut to the access width and byte-reversed. It is returned right-justified on `host_rdata` with the upper bits zero.
- R7: If `sel_ext` is low and the dword offset is 256 or more, no request is issued. A read returns all ones of the access width, and a write has no effect.
- R8: If `sel_present` is low, no request is issued. A read returns all ones of the access width, and a write has no effect.
- R9: Outside the data window, an access that is not 8 bytes wide or not 8-byte aligned ends with `host_err` high and read data zero, and it changes no state. An illegal size/lane pair inside the window is treated the same way.
- R10: At most one request is outstanding. `cfg_req_valid` and its fields hold steady until `cfg_resp_valid`. `host_ready` is low while a request is outstanding and pulses for exactly one cycle per access.
- R11: An aligned 8-byte access to any other offset reads zero, ignores writes and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access pending; held until `host_ready` |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset in the bridge register region |
| host_size | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| host_wdata | input | 64 | Write value, right-justified |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 64 | Read value, valid with `host_ready` |
| host_err | output | 1 | Access rejected, valid with `host_ready` |
| sel_bus | output | 8 | Bus field of the address register |
| sel_devfn | output | 8 | Devfn field of the address register |
| sel_present | input | 1 | A device answers at `sel_bus`/`sel_devfn` |
| sel_ext | input | 1 | That device has 4 KB (extended) configuration space |
| cfg_req_valid | output | 1 | Downstream request outstanding |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Target bus |
| cfg_req_devfn | output | 8 | Target device/function |
| cfg_req_off | output | 12 | Dword-aligned register offset |
| cfg_req_size | output | 2 | Access width code |
| cfg_req_be | output | 4 | Little-endian byte enables |
| cfg_req_wdata | output | 32 | Little-endian write dword |
| cfg_resp_valid | input | 1 | Response for the outstanding request |
| cfg_resp_rdata | input | 32 | Little-endian read dword |

## Verification
Directed accesses use recognisable byte patterns at each legal size and lane. Each pattern gives a different value when the bytes are reversed, shifted or left in place, so any mistake in the swap or the lane steering shows up in the result. Targets are set up in three ways: missing, conventional with an offset past 255, and extended. These show whether filtering depends on device presence, on the space size, or on neither. Illegal sizes and misaligned offsets, inside and outside the window, are checked for errors and for changes to the address register. Random iterations then mix bus, devfn, offset, size, lane and direction, with random response delays.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  // Address register field positions
  localparam int BUS_LSB   = 52;
  localparam int DEVFN_LSB = 44;
  localparam int OFF_LSB   = 32;

  typedef enum logic [1:0] {ACC_ERR, ACC_ADDR, ACC_OTHER, ACC_WIN} acc_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} bridge_state_e;

  function automatic int size_bytes(input logic [1:0] sz);
    return (sz == 2'd3) ? 4 : (1 << sz);
  endfunction

  // Reverse the low size_bytes(sz) bytes of v
  function automatic logic [31:0] swap_bytes(input logic [31:0] v, input logic [1:0] sz);
    logic [31:0] r;
    int n;
    r = '0;
    n = size_bytes(sz);
    for (int i = 0; i < 4; i++)
      if (i < n) r[8*i +: 8] = v[8*(n-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] width_ones(input logic [1:0] sz);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = (i < size_bytes(sz)) ? 8'hFF : 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
  import cfgb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_REG_OFF = 'h000,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h008
)(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output acc_kind_e         kind_o
);
  logic win_hit, win_legal;

  assign win_hit   = ({addr_i[ADDR_W-1:2], 2'b00} == DATA_OFF);
  assign win_legal = (size_i == 2'd0) ||
                     (size_i == 2'd1 && !addr_i[0]) ||
                     (size_i == 2'd2 && addr_i[1:0] == 2'b00);

  always_comb begin
    if (win_hit)
      kind_o = win_legal ? ACC_WIN : ACC_ERR;
    else if (size_i != 2'd3 || addr_i[2:0] != 3'b000)
      kind_o = ACC_ERR;
    else if (addr_i == ADDR_REG_OFF)
      kind_o = ACC_ADDR;
    else
      kind_o = ACC_OTHER;
  end
endmodule

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int OFF_W = 12
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q,
  output logic [7:0]       bus,
  output logic [7:0]       devfn,
  output logic [OFF_W-1:0] dw_off
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data;
  end

  assign bus    = q[BUS_LSB +: 8];
  assign devfn  = q[DEVFN_LSB +: 8];
  assign dw_off = {q[OFF_LSB+2 +: OFF_W-2], 2'b00};
endmodule

// File: rtl/cfgb_lanes.sv
module cfgb_lanes
  import cfgb_pkg::*;
#(
  parameter int DW = 32,
  parameter int NB = DW / 8
)(
  input  logic [1:0]    sz_i,
  input  logic [1:0]    lane_i,
  input  logic [DW-1:0] host_w_i,
  input  logic [DW-1:0] resp_i,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wdata_le_o,
  output logic [DW-1:0] rdata_be_o
);
  logic [3:0]    nbytes;
  logic [3:0]    lane_end;
  logic [DW-1:0] ones, shifted_r;

  assign nbytes   = 4'(size_bytes(sz_i));
  assign lane_end = {2'b00, lane_i} + nbytes;
  assign ones     = width_ones(sz_i);

  for (genvar g = 0; g < NB; g++) begin : g_be
    assign be_o[g] = (4'(g) >= {2'b00, lane_i}) && (4'(g) < lane_end);
  end

  assign wdata_le_o = swap_bytes(host_w_i & ones, sz_i) << {lane_i, 3'b000};
  assign shifted_r  = resp_i >> {lane_i, 3'b000};
  assign rdata_be_o = swap_bytes(shifted_r & ones, sz_i);
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
  import cfgb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_REG_OFF = 'h000,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h008,
  parameter int CONV_CFG_BYTES = 256,
  parameter int EXT_CFG_BYTES = 4096
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [63:0]       host_wdata,
  output logic              host_ready,
  output logic [63:0]       host_rdata,
  output logic              host_err,
  output logic [7:0]        sel_bus,
  output logic [7:0]        sel_devfn,
  input  logic              sel_present,
  input  logic              sel_ext,
  output logic              cfg_req_valid,
  output logic              cfg_req_write,
  output logic [7:0]        cfg_req_bus,
  output logic [7:0]        cfg_req_devfn,
  output logic [11:0]       cfg_req_off,
  output logic [1:0]        cfg_req_size,
  output logic [3:0]        cfg_req_be,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_resp_valid,
  input  logic [31:0]       cfg_resp_rdata
);
  localparam int OFF_W = $clog2(EXT_CFG_BYTES);
  localparam int LIM_W = OFF_W + 1;
  localparam logic [LIM_W-1:0] LIM_CONV = LIM_W'(CONV_CFG_BYTES);
  localparam logic [LIM_W-1:0] LIM_EXT  = LIM_W'(EXT_CFG_BYTES);

  bridge_state_e state;
  acc_kind_e     kind;
  logic [63:0]   addr_q;
  logic [OFF_W-1:0] dw_off;
  logic          addr_wr, in_range, idle_take;
  logic [1:0]    lane_sz, lane_sel, lat_lane;
  logic [3:0]    be_c;
  logic [31:0]   wle_c, rbe_c;

  cfgb_decode #(.ADDR_W(ADDR_W), .ADDR_REG_OFF(ADDR_REG_OFF), .DATA_OFF(DATA_OFF)) u_dec (
    .addr_i(host_addr), .size_i(host_size), .kind_o(kind));

  assign idle_take = (state == ST_IDLE) && host_valid;
  assign addr_wr   = idle_take && host_write && (kind == ACC_ADDR);

  cfgb_addr_reg #(.REG_W(64), .OFF_W(OFF_W)) u_areg (
    .clk(clk), .rst(rst), .wr_en(addr_wr), .wr_data(host_wdata),
    .q(addr_q), .bus(sel_bus), .devfn(sel_devfn), .dw_off(dw_off));

  assign lane_sz  = (state == ST_IDLE) ? host_size : cfg_req_size;
  assign lane_sel = (state == ST_IDLE) ? host_addr[1:0] : lat_lane;

  cfgb_lanes #(.DW(32)) u_lanes (
    .sz_i(lane_sz), .lane_i(lane_sel), .host_w_i(host_wdata[31:0]),
    .resp_i(cfg_resp_rdata), .be_o(be_c), .wdata_le_o(wle_c), .rdata_be_o(rbe_c));

  assign in_range = ({1'b0, dw_off} < (sel_ext ? LIM_EXT : LIM_CONV));

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      host_ready    <= 1'b0;
      host_rdata    <= '0;
      host_err      <= 1'b0;
      cfg_req_valid <= 1'b0;
      cfg_req_write <= 1'b0;
      cfg_req_bus   <= '0;
      cfg_req_devfn <= '0;
      cfg_req_off   <= '0;
      cfg_req_size  <= '0;
      cfg_req_be    <= '0;
      cfg_req_wdata <= '0;
      lat_lane      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (host_valid) begin
          host_err   <= (kind == ACC_ERR);
          host_rdata <= '0;
          host_ready <= 1'b1;
          state      <= ST_DONE;
          case (kind)
            ACC_ADDR: if (!host_write) host_rdata <= addr_q;
            ACC_WIN: begin
              if (sel_present && in_range) begin
                host_ready    <= 1'b0;
                state         <= ST_WAIT;
                cfg_req_valid <= 1'b1;
                cfg_req_write <= host_write;
                cfg_req_bus   <= sel_bus;
                cfg_req_devfn <= sel_devfn;
                cfg_req_off   <= 12'(dw_off);
                cfg_req_size  <= host_size;
                cfg_req_be    <= be_c;
                cfg_req_wdata <= host_write ? wle_c : 32'h0;
                lat_lane      <= host_addr[1:0];
              end else if (!host_write) begin
                host_rdata <= {32'h0, width_ones(host_size)};
              end
            end
            default: ;
          endcase
        end
        ST_WAIT: if (cfg_resp_valid) begin
          cfg_req_valid <= 1'b0;
          host_rdata    <= cfg_req_write ? 64'h0 : {32'h0, rbe_c};
          host_ready    <= 1'b1;
          state         <= ST_DONE;
        end
        default: begin
          host_ready <= 1'b0;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  // R10
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> !host_ready);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_valid && !cfg_resp_valid) |=>
      (cfg_req_valid && $stable(cfg_req_off) && $stable(cfg_req_be) && $stable(cfg_req_wdata)));
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);
  // R3
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> (cfg_req_off[1:0] == 2'b00));
  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> ($countones(cfg_req_be) == 1 || $countones(cfg_req_be) == 2 ||
                       $countones(cfg_req_be) == 4));
  // R9
  err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (host_ready && host_err) |-> !$past(cfg_req_valid));
endmodule

// File: tb/cfg_bridge_test.sv
module cfg_bridge_test;
  logic clk = 0, rst = 1;
  logic host_valid = 0, host_write = 0;
  logic [11:0] host_addr = 0;
  logic [1:0]  host_size = 0;
  logic [63:0] host_wdata = 0;
  logic host_ready, host_err;
  logic [63:0] host_rdata;
  logic [7:0] sel_bus, sel_devfn;
  logic sel_present, sel_ext;
  logic cfg_req_valid, cfg_req_write;
  logic [7:0] cfg_req_bus, cfg_req_devfn;
  logic [11:0] cfg_req_off;
  logic [1:0] cfg_req_size;
  logic [3:0] cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic cfg_resp_valid = 0;
  logic [31:0] cfg_resp_rdata = 0;

  int checks = 0, errors = 0, req_count = 0;
  logic [7:0] cap_bus, cap_devfn;
  logic [11:0] cap_off;
  logic [3:0] cap_be;
  logic [31:0] cap_wdata;
  logic cap_write;

  always #5 clk = ~clk;

  // Lookup model: bus 0xFF is empty; odd devfn is a conventional device
  assign sel_present = (sel_bus != 8'hFF);
  assign sel_ext     = ~sel_devfn[0];

  cfg_bridge uut (.*);

  function automatic logic [31:0] resp_model(input logic [7:0] b, input logic [7:0] d, input logic [11:0] o);
    return {b, d, 4'hA, o};
  endfunction

  function automatic int nb(input logic [1:0] sz);
    return (sz == 3) ? 8 : (1 << sz);
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] v, input int n);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] ones_of(input int n);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req_valid && !cfg_resp_valid) begin
        req_count++;
        cap_bus = cfg_req_bus; cap_devfn = cfg_req_devfn; cap_off = cfg_req_off;
        cap_be = cfg_req_be; cap_wdata = cfg_req_wdata; cap_write = cfg_req_write;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        cfg_resp_rdata = resp_model(cap_bus, cap_devfn, cap_off);
        cfg_resp_valid = 1;
        @(negedge clk);
        cfg_resp_valid = 0;
      end
    end
  end

  task automatic acc(input bit wr, input logic [11:0] a, input logic [1:0] sz, input logic [63:0] wd,
                     output logic [63:0] rd, output logic er, output int nreq);
    int start;
    start = req_count;
    @(negedge clk);
    host_valid = 1; host_write = wr; host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    rd = host_rdata; er = host_err; nreq = req_count - start;
    host_valid = 0;
  endtask

  task automatic set_target(input logic [7:0] b, input logic [7:0] d, input logic [11:0] o);
    logic [63:0] rd; logic er; int n;
    acc(1, 12'h000, 2'd3, {4'h0, b, d, o, 32'h0}, rd, er, n);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd; logic er; int n;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!host_ready && !cfg_req_valid, "R1", {host_ready, cfg_req_valid}, 0);
    acc(0, 12'h000, 2'd3, 0, rd, er, n);
    chk(rd == 0 && !er, "R1", rd, 0);

    // R2 address register
    acc(1, 12'h000, 2'd3, 64'h5123_4567_89AB_CDEF, rd, er, n);
    acc(0, 12'h000, 2'd3, 0, rd, er, n);
    chk(rd == 64'h5123_4567_89AB_CDEF, "R2", rd, 64'h5123_4567_89AB_CDEF);
    chk(sel_bus == 8'h12 && sel_devfn == 8'h34, "R2", {sel_bus, sel_devfn}, 16'h1234);

    // R3 R5: 4-byte write
    set_target(8'h12, 8'h34, 12'h0A7);
    acc(1, 12'h008, 2'd2, 64'h1122_3344, rd, er, n);
    chk(n == 1 && cap_off == 12'h0A4 && cap_bus == 8'h12 && cap_devfn == 8'h34, "R3", cap_off, 12'h0A4);
    chk(cap_wdata == 32'h4433_2211 && cap_be == 4'hF && cap_write, "R5", cap_wdata, 32'h4433_2211);
    // R4: byte lane 2
    acc(1, 12'h00A, 2'd0, 64'hAB, rd, er, n);
    chk(cap_be == 4'b0100 && cap_wdata == 32'h00AB_0000, "R4", {cap_be, cap_wdata}, {4'b0100, 32'h00AB_0000});
    // R6: 2-byte read lane 2
    acc(0, 12'h00A, 2'd1, 0, rd, er, n);
    chk(n == 1 && rd == 64'h3412 && !er, "R6", rd, 64'h3412);

    // R7: conventional device past 255
    set_target(8'h20, 8'h35, 12'h100);
    acc(0, 12'h008, 2'd1, 0, rd, er, n);
    chk(n == 0 && rd == 64'hFFFF, "R7", rd, 64'hFFFF);
    acc(1, 12'h008, 2'd2, 64'h55, rd, er, n);
    chk(n == 0 && !er, "R7", n, 0);
    // extended device at same offset goes through
    set_target(8'h20, 8'h36, 12'h100);
    acc(0, 12'h008, 2'd2, 0, rd, er, n);
    chk(n == 1 && rd == 64'(rev(resp_model(8'h20, 8'h36, 12'h100), 4)), "R7", rd, 0);

    // R8: missing device
    set_target(8'hFF, 8'h00, 12'h010);
    acc(0, 12'h008, 2'd2, 0, rd, er, n);
    chk(n == 0 && rd == 64'hFFFF_FFFF, "R8", rd, 64'hFFFF_FFFF);
    acc(1, 12'h009, 2'd0, 64'h77, rd, er, n);
    chk(n == 0 && !er && rd == 0, "R8", n, 0);

    // R9: rejected accesses
    set_target(8'h01, 8'h02, 12'h004);
    acc(0, 12'h00A, 2'd2, 0, rd, er, n);
    chk(er && n == 0 && rd == 0, "R9", {er, rd[62:0]}, 64'h8000_0000_0000_0000);
    acc(1, 12'h008, 2'd3, 64'h1, rd, er, n);
    chk(er && n == 0, "R9", er, 1);
    acc(1, 12'h000, 2'd2, 64'hDEAD, rd, er, n);
    chk(er, "R9", er, 1);
    acc(1, 12'h004, 2'd3, 64'hDEAD, rd, er, n);
    chk(er, "R9", er, 1);
    acc(0, 12'h000, 2'd3, 0, rd, er, n);
    chk(rd == {4'h0, 8'h01, 8'h02, 12'h004, 32'h0}, "R9", rd, {4'h0, 8'h01, 8'h02, 12'h004, 32'h0});

    // R11: other register
    acc(1, 12'h010, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, er, n);
    chk(!er && n == 0, "R11", er, 0);
    acc(0, 12'h010, 2'd3, 0, rd, er, n);
    chk(!er && rd == 0, "R11", rd, 0);
    acc(0, 12'h000, 2'd3, 0, rd, er, n);
    chk(rd == {4'h0, 8'h01, 8'h02, 12'h004, 32'h0}, "R11", rd, 0);

    // Random mix
    for (int it = 0; it < 150; it++) begin
      logic [7:0] b, d; logic [11:0] o; logic [1:0] sz, ln; bit wr; logic [63:0] wd;
      logic [31:0] exp_r; bit ok; int nbytes;
      b = 8'($urandom); if ($urandom_range(0, 7) == 0) b = 8'hFF;
      d = 8'($urandom); o = 12'($urandom);
      sz = 2'($urandom_range(0, 2));
      ln = (sz == 0) ? 2'($urandom_range(0, 3)) : (sz == 1) ? {1'($urandom_range(0, 1)), 1'b0} : 2'd0;
      wr = 1'($urandom_range(0, 1)); wd = {$urandom, $urandom};
      nbytes = nb(sz);
      set_target(b, d, o);
      acc(wr, {10'h002, ln}, sz, wd, rd, er, n);
      ok = (b != 8'hFF) && (!d[0] || (o & 12'hFFC) < 12'h100);
      if (ok) begin
        chk(n == 1 && cap_off == (o & 12'hFFC) && cap_bus == b && cap_devfn == d, "R3", cap_off, o & 12'hFFC);
        if (wr)
          chk(cap_wdata == (rev(wd[31:0] & ones_of(nbytes), nbytes) << (8*ln)) &&
              cap_be == 4'(((1 << nbytes) - 1) << ln), "R5", cap_wdata, 0);
        else begin
          exp_r = rev((resp_model(b, d, o & 12'hFFC) >> (8*ln)) & ones_of(nbytes), nbytes);
          chk(rd == 64'(exp_r), "R6", rd, 64'(exp_r));
        end
      end else begin
        chk(n == 0 && rd == (wr ? 64'h0 : 64'(ones_of(nbytes))), (b == 8'hFF) ? "R8" : "R7", rd, 64'(ones_of(nbytes)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule